// File: doc/BRIEF.md
# Clock-Correction Sequence Matcher

This block watches a receive symbol stream, one symbol per clock, and reports when one of two programmable clock-correction sequences has just gone by. An elastic buffer next to it uses the pulse to decide where a symbol may be inserted or dropped. Each sequence has one to four subsequence symbols. The two sequences share one length setting. Each sequence has its own symbol values and its own per-position don't-care mask. The second sequence is looked for only when it is switched on.

The matcher can take either the raw 10-bit line symbols or the output of an 8B/10B decoder. The decoder output is a data byte, a K flag and a disparity-error flag. In the decoded case a byte matches whatever its running disparity. The compare width follows the datapath mode: ten bits, or only the low eight bits. A separate flag leaves bit 9 out of every compare. The block keeps the four most recent symbols. When the last of them completes a sequence, it raises a one-cycle pulse together with a sequence identifier.

Top module: `ccm_matcher`

## Requirements
- R1: `len_i` = n (0..3) selects n+1 subsequence symbols. Subsequence j sits at bits [10j+9:10j] of `seq1_i`/`seq2_i`. Subsequence 0 must be the earliest symbol received, and the others must follow in index order on consecutive clocks.
- R2: `match_o` is high for exactly the one clock cycle after the rising edge that captures the final symbol of a matching window. In that cycle `seq2_hit_o` is 0 when sequence 1 matched and 1 when only sequence 2 matched.
- R3: With `cmp8_i`=0 and `disp_chk_i`=1, all ten bits of each enabled subsequence must equal the captured symbol.
- R4: With `cmp8_i`=1, only bits 7:0 are compared, and bits 9:8 of symbols and subsequences have no effect.
- R5: Sequence 2 can produce a match only while `seq2_on_i`=1. It uses `len_i` with its own values `seq2_i` and its own mask `seq2_en_i`.
- R6: When both sequences match in the same cycle, `seq2_hit_o` is 0.
- R7: With `src_dec_i`=1, the captured symbol is {`dec_derr_i`, `dec_k_i`, `dec_data_i`}. Bit 8 is the K flag, bit 9 the inverted-disparity flag, and `raw_i` is ignored.
- R8: With `src_dec_i`=0, the captured symbol is `raw_i`, and the decoded inputs are ignored.
- R9: With `disp_chk_i`=0, bit 9 is excluded from every compare.
- R10: A 0 in bit j of `seq1_en_i`/`seq2_en_i` makes position j match for any symbol.
- R11: Matches may overlap or follow one another directly. A new window may end on the symbol right after a previous match.
- R12: Reset clears the symbol history and holds `match_o` and `seq2_hit_o` at 0. After reset no match is reported until at least n+1 new symbols have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 10 | Undecoded line symbol |
| dec_data_i | input | 8 | Decoded data byte |
| dec_k_i | input | 1 | Decoded K-character flag |
| dec_derr_i | input | 1 | Decoded disparity-error flag |
| seq1_i | input | 40 | Sequence 1 subsequences, position 0 in the low bits |
| seq2_i | input | 40 | Sequence 2 subsequences |
| seq1_en_i | input | 4 | Sequence 1 position compare enables |
| seq2_en_i | input | 4 | Sequence 2 position compare enables |
| len_i | input | 2 | Sequence length minus one |
| seq2_on_i | input | 1 | Enable the second sequence |
| src_dec_i | input | 1 | 1 = decoded source, 0 = raw |
| cmp8_i | input | 1 | 1 = compare bits 7:0 only |
| disp_chk_i | input | 1 | 1 = include bit 9 in compares |
| match_o | output | 1 | Sequence match pulse |
| seq2_hit_o | output | 1 | Match came from sequence 2 |

## Verification
Streams carry full sequences, truncated prefixes, reversed orders and single-bit corruptions, which separate the ordering and length logic from the bit compare. Symbols that differ only in bits 9:8 tell the 8-bit and 10-bit compare modes apart. Decoded symbols that differ only in the K or disparity flag, and raw garbage sent alongside valid decoded data, show which source is captured and which bits count. Repeated symbols with length 1 and 2, masked positions, both sequences matching at once, and a reset in the middle of a sequence cover overlap, don't-care, priority and history clearing.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int SYM_W = 10;
  typedef logic [SYM_W-1:0] sym_t;

  // bits that take part in a symbol compare
  function automatic sym_t care_bits(input logic cmp8, input logic disp_chk);
    if (cmp8) return sym_t'(10'h0FF);
    if (!disp_chk) return sym_t'(10'h1FF);
    return sym_t'(10'h3FF);
  endfunction

  function automatic logic sym_eq(input sym_t a, input sym_t b, input sym_t care);
    return ((a ^ b) & care) == '0;
  endfunction
endpackage

// File: rtl/ccm_sym_hist.sv
module ccm_sym_hist
  import ccm_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   src_dec_i,
  input  logic [SYM_W-1:0]       raw_i,
  input  logic [7:0]             dec_data_i,
  input  logic                   dec_k_i,
  input  logic                   dec_derr_i,
  output logic [DEPTH*SYM_W-1:0] hist_o,
  output logic [FILL_W-1:0]      fill_o
);
  sym_t in_sym;
  sym_t stage_q [DEPTH];
  logic [FILL_W-1:0] fill_q;

  always_comb in_sym = src_dec_i ? {dec_derr_i, dec_k_i, dec_data_i} : raw_i;

  // stage 0 holds the newest symbol
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= in_sym;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (fill_q != FILL_W'(DEPTH)) fill_q <= fill_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign hist_o[g*SYM_W +: SYM_W] = stage_q[g];
  end
  assign fill_o = fill_q;

  AST_SHIFT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[1] == $past(stage_q[0])); // R1
  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q != FILL_W'(DEPTH)) |=> fill_q == $past(fill_q) + 1'b1); // R12
  AST_FILL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_q) <= DEPTH); // R12
endmodule

// File: rtl/ccm_seq_cmp.sv
module ccm_seq_cmp
  import ccm_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 2
) (
  input  logic [DEPTH*SYM_W-1:0] hist_i,
  input  logic [DEPTH*SYM_W-1:0] seq_i,
  input  logic [DEPTH-1:0]       pos_en_i,
  input  logic [LEN_W-1:0]       len_i,
  input  sym_t                   care_i,
  output logic                   hit_o
);
  sym_t win [DEPTH];
  logic [DEPTH-1:0] pos_ok;

  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    assign win[g] = hist_i[g*SYM_W +: SYM_W];
  end

  // position j (0 = earliest) lines up with history slot len-j
  for (genvar j = 0; j < DEPTH; j++) begin : g_pos
    logic [LEN_W-1:0] idx;
    assign idx = len_i - LEN_W'(j);
    assign pos_ok[j] = (j > int'(len_i)) || !pos_en_i[j] ||
                       sym_eq(win[idx], seq_i[j*SYM_W +: SYM_W], care_i);
  end

  assign hit_o = &pos_ok;
endmodule

// File: rtl/ccm_matcher.sv
module ccm_matcher
  import ccm_pkg::*;
#(
  parameter int SEQ_MAX = 4,
  localparam int LEN_W = $clog2(SEQ_MAX),
  localparam int FILL_W = $clog2(SEQ_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [9:0]               raw_i,
  input  logic [7:0]               dec_data_i,
  input  logic                     dec_k_i,
  input  logic                     dec_derr_i,
  input  logic [SEQ_MAX*10-1:0]    seq1_i,
  input  logic [SEQ_MAX*10-1:0]    seq2_i,
  input  logic [SEQ_MAX-1:0]       seq1_en_i,
  input  logic [SEQ_MAX-1:0]       seq2_en_i,
  input  logic [LEN_W-1:0]         len_i,
  input  logic                     seq2_on_i,
  input  logic                     src_dec_i,
  input  logic                     cmp8_i,
  input  logic                     disp_chk_i,
  output logic                     match_o,
  output logic                     seq2_hit_o
);
  localparam int NSEQ = 2;

  logic [SEQ_MAX*SYM_W-1:0] hist;
  logic [FILL_W-1:0]        fill;
  logic [SEQ_MAX*SYM_W-1:0] seq_v [NSEQ];
  logic [SEQ_MAX-1:0]       en_v  [NSEQ];
  logic [NSEQ-1:0]          hit;
  sym_t                     care;
  logic                     window_ok;

  ccm_sym_hist #(.DEPTH(SEQ_MAX)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_dec_i  (src_dec_i),
    .raw_i      (raw_i),
    .dec_data_i (dec_data_i),
    .dec_k_i    (dec_k_i),
    .dec_derr_i (dec_derr_i),
    .hist_o     (hist),
    .fill_o     (fill)
  );

  assign care     = care_bits(cmp8_i, disp_chk_i);
  assign seq_v[0] = seq1_i;
  assign seq_v[1] = seq2_i;
  assign en_v[0]  = seq1_en_i;
  assign en_v[1]  = seq2_en_i;

  for (genvar s = 0; s < NSEQ; s++) begin : g_seq
    ccm_seq_cmp #(.DEPTH(SEQ_MAX), .LEN_W(LEN_W)) u_cmp (
      .hist_i   (hist),
      .seq_i    (seq_v[s]),
      .pos_en_i (en_v[s]),
      .len_i    (len_i),
      .care_i   (care),
      .hit_o    (hit[s])
    );
  end

  // enough symbols captured since reset to fill the window
  assign window_ok  = int'(fill) > int'(len_i);
  assign match_o    = window_ok && (hit[0] || (seq2_on_i && hit[1]));
  assign seq2_hit_o = window_ok && !hit[0] && seq2_on_i && hit[1];

  AST_NO_EARLY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fill) <= int'(len_i)) |-> !match_o); // R12
  AST_SEQ2_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq2_hit_o |-> (match_o && seq2_on_i)); // R5
  AST_SEQ1_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_ok && hit[0]) |-> (match_o && !seq2_hit_o)); // R6
  AST_ALL_DONTCARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (window_ok && seq1_en_i == '0) |-> match_o); // R10
endmodule

// File: tb/ccm_matcher_test.sv
`timescale 1ns/1ps
module ccm_matcher_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic [9:0] raw_i = '0;
  logic [7:0] dec_data_i = '0;
  logic dec_k_i = 1'b0, dec_derr_i = 1'b0;
  logic [39:0] c_seq1 = '0, c_seq2 = '0;
  logic [3:0] c_en1 = '0, c_en2 = '0;
  logic [1:0] c_len = '0;
  logic c_s2on = 1'b0, c_dec = 1'b0, c_cmp8 = 1'b0, c_disp = 1'b1;
  logic match_o, seq2_hit_o;

  ccm_matcher uut (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw_i), .dec_data_i(dec_data_i),
    .dec_k_i(dec_k_i), .dec_derr_i(dec_derr_i), .seq1_i(c_seq1), .seq2_i(c_seq2),
    .seq1_en_i(c_en1), .seq2_en_i(c_en2), .len_i(c_len), .seq2_on_i(c_s2on),
    .src_dec_i(c_dec), .cmp8_i(c_cmp8), .disp_chk_i(c_disp),
    .match_o(match_o), .seq2_hit_o(seq2_hit_o)
  );

  localparam logic [9:0] A = 10'h17C, B = 10'h283, C = 10'h2AA, D = 10'h155;

  int n_vec = 0, n_err = 0;
  bit done = 0;
  logic [9:0] m_hist [4];
  int m_fill = 0;
  logic q_m [$];
  logic q_s [$];
  string q_t [$];

  function automatic logic [9:0] care();
    if (c_cmp8) return 10'h0FF;
    return c_disp ? 10'h3FF : 10'h1FF;
  endfunction

  function automatic logic model_hit(input logic [39:0] s, input logic [3:0] en);
    int len = int'(c_len);
    if (m_fill < len + 1) return 1'b0;
    for (int j = 0; j <= len; j++)
      if (en[j] && ((m_hist[len-j] ^ s[j*10 +: 10]) & care()) != 0) return 1'b0;
    return 1'b1;
  endfunction

  // driver: apply one symbol, predict result, queue it
  task automatic send(input logic [9:0] r, input logic [7:0] d, input logic k,
                      input logic e, input string tag);
    logic h1, h2;
    raw_i = r; dec_data_i = d; dec_k_i = k; dec_derr_i = e;
    @(posedge clk);
    for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = c_dec ? {e, k, d} : r;
    if (m_fill < 4) m_fill++;
    h1 = model_hit(c_seq1, c_en1);
    h2 = c_s2on && model_hit(c_seq2, c_en2);
    q_m.push_back(h1 | h2);
    q_s.push_back(!h1 && h2);
    q_t.push_back(tag);
    #1;
  endtask

  task automatic send_raw(input logic [9:0] r, input string tag);
    send(r, 8'h00, 1'b0, 1'b0, tag);
  endtask

  task automatic rst_on();
    @(negedge clk); #1;
    rst_ni = 1'b0;
    m_fill = 0;
    for (int i = 0; i < 4; i++) m_hist[i] = '0;
  endtask

  task automatic rst_off();
    @(negedge clk);
    n_vec++;
    if (match_o !== 1'b0 || seq2_hit_o !== 1'b0) begin
      n_err++;
      $display("FAIL R12 reset: match=%b seq2=%b expected match=0 seq2=0", match_o, seq2_hit_o);
    end
    @(posedge clk); #1;
    rst_ni = 1'b1;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q_m.size() != 0) begin
      logic em, es;
      string t;
      em = q_m.pop_front(); es = q_s.pop_front(); t = q_t.pop_front();
      n_vec++;
      if (match_o !== em || seq2_hit_o !== es) begin
        n_err++;
        $display("FAIL %s: match=%b seq2=%b expected match=%b seq2=%b",
                 t, match_o, seq2_hit_o, em, es);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_hist[i] = '0;
    // R1 R3 R8: raw, 4 symbols, 10-bit compare
    c_seq1 = {D, C, B, A}; c_en1 = 4'hF; c_seq2 = {A, A, A, A}; c_en2 = 4'hF;
    c_len = 2'd3; c_s2on = 1'b0; c_dec = 1'b0; c_cmp8 = 1'b0; c_disp = 1'b1;
    repeat (2) @(posedge clk); #1;
    rst_off();
    send_raw(A, "R12"); send_raw(B, "R12"); send_raw(C, "R12"); send_raw(D, "R12");
    send_raw(10'h000, "R2");
    send_raw(A, "R1"); send_raw(B, "R1"); send_raw(C, "R1"); send_raw(D, "R1");
    send_raw(A, "R1"); send_raw(B, "R1"); send_raw(C, "R1"); send_raw(10'h001, "R1");
    send_raw(D, "R1"); send_raw(C, "R1"); send_raw(B, "R1"); send_raw(A, "R1");
    send_raw(A, "R3"); send_raw(B, "R3"); send_raw(C, "R3"); send_raw(D ^ 10'h200, "R3");
    // R8: decoded inputs carry the pattern, raw does not
    send(10'h3FF, A[7:0], A[8], A[9], "R8"); send(10'h3FF, B[7:0], B[8], B[9], "R8");
    send(10'h3FF, C[7:0], C[8], C[9], "R8"); send(10'h3FF, D[7:0], D[8], D[9], "R8");

    // R11: overlap with len 1 and len 2
    rst_on(); c_len = 2'd0; c_seq1 = {D, C, B, A}; rst_off();
    send_raw(A, "R11"); send_raw(A, "R11"); send_raw(B, "R11"); send_raw(A, "R11");
    rst_on(); c_len = 2'd1; c_seq1 = {D, C, A, A}; rst_off();
    send_raw(A, "R11"); send_raw(A, "R11"); send_raw(A, "R11"); send_raw(B, "R11");
    send_raw(A, "R11");

    // R4: 8-bit compare ignores bits 9:8
    rst_on(); c_len = 2'd1; c_seq1 = {D, C, B, A}; c_cmp8 = 1'b1; rst_off();
    send_raw(A ^ 10'h300, "R4"); send_raw(B ^ 10'h100, "R4");
    send_raw(A, "R4"); send_raw(B ^ 10'h001, "R4");
    // R3: same stream with 10-bit compare
    rst_on(); c_cmp8 = 1'b0; rst_off();
    send_raw(A ^ 10'h300, "R3"); send_raw(B ^ 10'h100, "R3");
    send_raw(A, "R3"); send_raw(B, "R3");

    // R5: second sequence gated by its enable
    rst_on(); c_seq2 = {A, B, D, C}; c_en2 = 4'hF; c_s2on = 1'b0; rst_off();
    send_raw(C, "R5"); send_raw(D, "R5");
    rst_on(); c_s2on = 1'b1; rst_off();
    send_raw(C, "R5"); send_raw(D, "R5"); send_raw(A, "R2"); send_raw(B, "R2");
    // R6: both sequences match together
    rst_on(); c_seq2 = {D, C, B, A}; rst_off();
    send_raw(A, "R6"); send_raw(B, "R6"); send_raw(C, "R6");
    c_s2on = 1'b1;

    // R7 R9: decoded source
    rst_on(); c_s2on = 1'b0; c_dec = 1'b1; c_disp = 1'b1;
    c_seq1 = {10'h000, 10'h000, 10'h050, 10'h1BC}; rst_off();
    send(10'h2AA, 8'hBC, 1'b1, 1'b0, "R7"); send(10'h155, 8'h50, 1'b0, 1'b0, "R7");
    send(10'h1BC, 8'hBC, 1'b0, 1'b0, "R7"); send(10'h050, 8'h50, 1'b0, 1'b0, "R7");
    send(10'h000, 8'hBC, 1'b1, 1'b1, "R9"); send(10'h000, 8'h50, 1'b0, 1'b0, "R9");
    rst_on(); c_disp = 1'b0; rst_off();
    send(10'h000, 8'hBC, 1'b1, 1'b1, "R9"); send(10'h000, 8'h50, 1'b0, 1'b0, "R9");
    send(10'h000, 8'hBC, 1'b0, 1'b1, "R7"); send(10'h000, 8'h50, 1'b0, 1'b0, "R7");

    // R10: positions 0 and 3 are don't-care
    rst_on(); c_dec = 1'b0; c_disp = 1'b1; c_len = 2'd3;
    c_seq1 = {D, C, B, A}; c_en1 = 4'b0110; rst_off();
    send_raw(10'h001, "R10"); send_raw(B, "R10"); send_raw(C, "R10"); send_raw(10'h002, "R10");
    send_raw(10'h003, "R10"); send_raw(B, "R10"); send_raw(10'h004, "R10"); send_raw(D, "R10");

    // R12: reset in the middle of a sequence
    rst_on(); c_en1 = 4'hF; rst_off();
    send_raw(A, "R12"); send_raw(B, "R12"); send_raw(C, "R12");
    rst_on(); rst_off();
    send_raw(D, "R12"); send_raw(A, "R12"); send_raw(B, "R12");
    send_raw(C, "R12"); send_raw(D, "R12");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule